// File: doc/BRIEF.md
# Packed High/Low Duty Cycle Meter

This block times the two phases of an external digital signal. It counts in ticks of a divided clock and holds both results in one read word. The duration of the most recent high phase sits in the lower half of the word, and the duration of the most recent low phase sits in the upper half. Each half is refreshed when its own phase ends, so a read always shows the latest complete high time and the latest complete low time together. Duty cycle, pulse width and period then follow in software.

The input passes through a synchronizer and an edge detector. A prescaler turns the system clock into ticks, with the divisor supplied on a port. A single phase counter restarts on every edge and feeds two capture registers. The divisor has to be chosen so that the longest expected phase fits in a half-word. If a phase runs longer, its count stops at the all-ones value and a sticky flag records the overflow.

Top module: `phase_span_meter`

## Requirements
- R1: `meas_word[CNT_W-1:0]` holds the high-phase count and `meas_word[2*CNT_W-1:CNT_W]` holds the low-phase count.
- R2: When the input falls after a high phase of H clock cycles (measured edge to edge), the lower half becomes min(floor(H/D), 2^CNT_W-1). D is the effective divisor. The new value is visible 3 clock cycles after the input transition.
- R3: When the input rises after a low phase of L clock cycles, the upper half becomes min(floor(L/D), 2^CNT_W-1).
- R4: The effective divisor D equals `tick_div`, and a `tick_div` of 0 behaves exactly like 1, giving one tick per clock cycle.
- R5: A constant input, at either level, changes neither half of `meas_word`, however long it is held.
- R6: A falling edge leaves the upper half unchanged, and a rising edge leaves the lower half unchanged.
- R7: `ovf_flag` rises when a measured phase reaches more than 2^CNT_W-1 ticks, and then stays high until reset. A phase of exactly 2^CNT_W-1 ticks does not set it.
- R8: While `rst` is high, `meas_word` and `ovf_flag` read 0 on the following cycle.
- R9: The first edge after reset only starts timing and captures nothing. A phase already in progress at reset is therefore never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_div | input | DIV_W | Prescaler divisor; 0 and 1 both mean one tick per clock cycle |
| sig_in | input | 1 | Asynchronous signal to be measured |
| meas_word | output | 2*CNT_W | Packed result: low-phase count in the upper half, high-phase count in the lower half |
| ovf_flag | output | 1 | Sticky flag set when a phase count saturates |

## Verification
An edge that ends a phase can arrive in the same cycle as a prescaler tick. The same edge can also arrive in the cycle where the counter would step past its maximum. The bench provokes the first case by sweeping phase lengths that are exact multiples of every divisor, including 0 and 1. It provokes the second with phases of exactly 255, 256 and 300 ticks on an 8-bit counter. Both cases are judged against floor(length/divisor) computed in the bench, and against the rule that the flag appears only when the tick count exceeds the maximum.

// File: rtl/psm_pkg.sv
package psm_pkg;
  // Edge events leaving the synchronizer, one cycle wide each
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/psm_edge_sync.sv
module psm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin,
  output psm_pkg::edge_t evt
);
  localparam int FILL_MAX = STAGES + 1;
  localparam int FILL_W   = $clog2(FILL_MAX + 1);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic [FILL_W-1:0] fill;
  logic              ready;

  assign ready = (fill == FILL_W'(FILL_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
      fill  <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
      if (!ready) fill <= fill + 1'b1;
    end
  end

  // Edges are held back until the chain holds real samples
  assign evt.rise = ready &  chain[STAGES-1] & ~prev;
  assign evt.fall = ready & ~chain[STAGES-1] &  prev;
endmodule

// File: rtl/psm_tick_gen.sv
module psm_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] pre;
  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] pos;

  // The edge cycle is treated as position 0 of the new phase
  assign last = (div == '0) ? '0 : div - 1'b1;
  assign pos  = restart ? '0 : pre;
  assign tick = (pos >= last);

  always_ff @(posedge clk) begin
    if (rst)          pre <= '0;
    else if (tick)    pre <= '0;
    else              pre <= pos + 1'b1;
  end
endmodule

// File: rtl/psm_span_ctr.sv
module psm_span_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             sat_hit
);
  localparam logic [CNT_W-1:0] MAX = '1;

  assign sat_hit = tick & ~restart & (cnt == MAX);

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (restart)              cnt <= tick ? CNT_W'(1) : '0;
    else if (tick && cnt != MAX)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phase_span_meter.sv
module phase_span_meter #(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_W-1:0]   tick_div,
  input  logic               sig_in,
  output logic [2*CNT_W-1:0] meas_word,
  output logic               ovf_flag
);
  psm_pkg::edge_t   evt;
  logic             any_edge;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             sat_hit;
  logic             armed;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;

  assign any_edge = evt.rise | evt.fall;

  psm_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(sig_in), .evt(evt)
  );

  psm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(tick_div), .restart(any_edge), .tick(tick)
  );

  psm_span_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .tick(tick), .restart(any_edge),
    .cnt(cnt), .sat_hit(sat_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (any_edge) armed <= 1'b1;
      if (armed && evt.fall) hi_q <= cnt;
      if (armed && evt.rise) lo_q <= cnt;
      if (armed && sat_hit) ovf_flag <= 1'b1;
    end
  end

  assign meas_word = {lo_q, hi_q};
endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               rise,
  input logic               fall,
  input logic [CNT_W-1:0]   cnt,
  input logic [2*CNT_W-1:0] word,
  input logic               ovf
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    // R8
    if (rst_q) reset_clear_chk: assert (word == '0 && !ovf);
  end

  // R6
  one_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));

  // R2
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(word[CNT_W-1:0]));

  // R3
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(word[2*CNT_W-1:CNT_W]));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(cnt) == {CNT_W{1'b1}});
endmodule

bind phase_span_meter psm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rise(evt.rise), .fall(evt.fall),
  .cnt(cnt), .word(meas_word), .ovf(ovf_flag)
);

// File: tb/sim_phase_span_meter.sv
`timescale 1ns/1ps
module sim_phase_span_meter;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] tick_div = '0;
  logic          sig_in = 1'b0;
  logic [2*CW-1:0] meas_word;
  logic          ovf_flag;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  phase_span_meter #(.CNT_W(CW), .DIV_W(DW), .STAGES(2)) u0 (
    .clk(clk), .rst(rst), .tick_div(tick_div), .sig_in(sig_in),
    .meas_word(meas_word), .ovf_flag(ovf_flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic lvl);
    @(negedge clk);
    rst = 1'b1;
    sig_in = lvl;
    step(2);
    rst = 1'b0;
    step(6);
  endtask

  function automatic int expect_cnt(input int len, input int d);
    int e;
    e = (d == 0) ? 1 : d;
    return (len / e > MAXV) ? MAXV : len / e;
  endfunction

  // R2 R3 R4: arm on a rise, time high h and low l, end with a rise
  task automatic run_pair(input int d, input int h, input int l);
    int eh, el, e;
    e = (d == 0) ? 1 : d;
    tick_div = DW'(d);
    do_reset(1'b0);
    sig_in = 1'b1; step(h);
    sig_in = 1'b0; step(l);
    sig_in = 1'b1; step(6);
    eh = expect_cnt(h, d);
    el = expect_cnt(l, d);
    chk($sformatf("R2 high d=%0d h=%0d", d, h), int'(meas_word[CW-1:0]), eh);
    chk($sformatf("R3 low d=%0d l=%0d", d, l), int'(meas_word[2*CW-1:CW]), el);
    chk($sformatf("R7 flag d=%0d", d), int'(ovf_flag),
        ((h / e > MAXV) || (l / e > MAXV)) ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hs[5] = '{1, 4, 7, 12, 30};
    int ls[3] = '{2, 9, 25};
    int ds[5] = '{0, 1, 2, 3, 5};
    logic [2*CW-1:0] snap;

    // R8: reset state
    step(3);
    chk("R8 word in reset", int'(meas_word), 0);
    chk("R8 flag in reset", int'(ovf_flag), 0);

    // R1 R2 R3 R4: sweep of divisors and phase lengths
    foreach (ds[i]) foreach (hs[j]) foreach (ls[k])
      run_pair(ds[i], hs[j], ls[k]);

    // R1: packing order with distinct halves
    run_pair(1, 17, 40);
    chk("R1 packed word", int'(meas_word), (40 << CW) | 17);

    // R5: constant input after valid captures
    snap = meas_word;
    step(400);
    chk("R5 held high", int'(meas_word), int'(snap));
    sig_in = 1'b0; step(6);
    snap = meas_word;
    step(400);
    chk("R5 held low", int'(meas_word), int'(snap));

    // R6: a fall must leave the upper half, a rise the lower half
    run_pair(2, 20, 30);
    sig_in = 1'b0; step(6);
    chk("R6 fall keeps low half", int'(meas_word[2*CW-1:CW]), 15);
    chk("R6 fall sets high half", int'(meas_word[CW-1:0]), 3);
    sig_in = 1'b1; step(6);
    chk("R6 rise keeps high half", int'(meas_word[CW-1:0]), 3);
    chk("R6 rise sets low half", int'(meas_word[2*CW-1:CW]), 3);

    // R7: saturation boundary
    run_pair(1, MAXV, 3);
    chk("R7 exact max no flag", int'(ovf_flag), 0);
    run_pair(1, MAXV + 1, 3);
    chk("R7 one past max", int'(meas_word[CW-1:0]), MAXV);
    run_pair(1, 300, 4);
    sig_in = 1'b0; step(10);
    sig_in = 1'b1; step(6);
    chk("R7 flag sticky", int'(ovf_flag), 1);
    chk("R7 next low after sat", int'(meas_word[2*CW-1:CW]), 10);

    // R8: reset clears after captures
    @(negedge clk); rst = 1'b1; step(1);
    chk("R8 word cleared", int'(meas_word), 0);
    chk("R8 flag cleared", int'(ovf_flag), 0);

    // R9: reset with input high; first fall captures nothing
    tick_div = DW'(1);
    do_reset(1'b1);
    step(10);
    sig_in = 1'b0; step(7);
    chk("R9 first fall no capture", int'(meas_word), 0);
    sig_in = 1'b1; step(6);
    chk("R9 low after arm", int'(meas_word[2*CW-1:CW]), 7);
    chk("R9 high still empty", int'(meas_word[CW-1:0]), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule